// File: doc/BRIEF.md
# Packed-Decimal Add/Subtract Unit

This unit is the arithmetic slice of an 8-bit processor datapath. It computes add-with-carry or subtract-with-borrow on two bytes, either as plain binary numbers or as two packed decimal digits per byte. Alongside the result byte it produces a status byte that carries negative, overflow, zero and carry.

A variant input picks one of two generations of the processor. The early generation takes some decimal flags from intermediate or binary values, and applies the subtract digit fix-up before the high-digit step. The later generation takes negative and zero from the final decimal byte, and applies a whole-byte fix-up after the high-digit step. Every input combination gives a defined result, including bytes that are not valid decimal.

The combinational result is captured in one output register, which has a synchronous active-high reset. A result appears on the outputs one clock after its inputs are presented.

Top module: `bcd_alu`

## Requirements
- R1: With `dec_en` low and `op_sub` low, result = (A + B + carry_in) mod 256. C is the carry out of bit 7, V is signed overflow, N is result bit 7, and Z is set when the result is 0x00.
- R2: With `dec_en` low and `op_sub` high, result = (A − B − (1 − carry_in)) mod 256. C = 1 means no borrow. V is signed overflow of the subtraction, N is result bit 7, and Z is set for a zero result.
- R3: In decimal add (both variants), low = A[3:0] + B[3:0] + carry_in. When low is 10 or more, 6 is added, the value is kept to 4 bits, and 0x10 is carried up. The high sum is A&0xF0 + B&0xF0 + low + that carry. If the high sum exceeds 8 bits or is at least 0xA0, 0x60 is added and C = 1; otherwise C = 0.
- R4: In decimal add, V is the signed overflow of the high sum before the 0x60 step. With `cmos_mode` low, N is bit 7 of that same pre-correction sum.
- R5: With `cmos_mode` low, decimal-add Z is the Z of the binary sum A + B + carry_in.
- R6: For `cmos_mode` low decimal subtract: low = A[3:0] − B[3:0] − (1 − carry_in). On a borrow, low = (low − 6) mod 16 and 0x10 more is taken from the high part. Then high = (A&0xF0 | low) − B&0xF0 − that 0x10. If high borrows, 0x60 is subtracted.
- R7: With `cmos_mode` low, decimal-subtract N, V, Z and C equal those of the binary subtraction in R2.
- R8: For `cmos_mode` high decimal subtract, a low-digit borrow only masks low to 4 bits and takes 0x10 from the high part. The 0x60 step is applied as in R6. Afterwards, if the low digit borrowed, 6 is subtracted from the whole byte (mod 256).
- R9: With `cmos_mode` high and `dec_en` high, N is bit 7 of the final result and Z flags a final result of 0x00. Subtract V and C are the binary-subtract flags. Add V and C follow R4 and R3.
- R10: Outputs change one clock after the inputs are sampled. While `rst` is high at a clock edge, the next result and status are 0x00.
- R11: `status_o` bit 7 is N, bit 6 is V, bit 1 is Z and bit 0 is C. Bits 5 to 2 are always 0.
- R12: A decimal add of two valid packed-decimal bytes yields the decimal sum mod 100 as packed digits, with C set when the sum is 100 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Incoming carry; for subtract 1 means no borrow |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_en | input | 1 | 1 = packed-decimal arithmetic |
| cmos_mode | input | 1 | 0 = early flag and fix-up behaviour, 1 = later behaviour |
| result_o | output | 8 | Registered result byte |
| status_o | output | 8 | Registered status byte {N,V,0,0,0,0,Z,C} |

## Verification
The hardest behaviour to reach is on invalid decimal operands, where the corrections interact in ways that normal use never shows. Examples are a high digit above 9 combined with a low-digit carry, and a subtract whose low and high parts both borrow. These cases decide the early and late variant differences in the subtract fix-up order and in zero detection. The stimulus therefore sweeps every first-operand byte against a stride of second-operand bytes, including 0x99 and 0xFF, with both carry values. The sweep covers each operation, mode and variant, so operand pairs that are out of decimal range on either digit occur on both sides.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DW = 8;
    localparam int NW = 4;

    localparam logic [NW:0]   LO_LIMIT    = 5'd10;
    localparam logic [NW-1:0] ADJ_NIB     = 4'd6;
    localparam logic [DW-1:0] HI_LIMIT    = 8'hA0;
    localparam logic [DW-1:0] ADJ_HI      = 8'h60;
    localparam logic [DW:0]   DIGIT_CARRY = 9'h010;

    localparam int ST_N = 7;
    localparam int ST_V = 6;
    localparam int ST_Z = 1;
    localparam int ST_C = 0;

    typedef enum logic {VAR_EARLY = 1'b0, VAR_LATE = 1'b1} variant_e;
    typedef enum logic [1:0] {
        SEL_BADD = 2'b00,
        SEL_BSUB = 2'b01,
        SEL_DADD = 2'b10,
        SEL_DSUB = 2'b11
    } path_sel_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] value;
        flags_t        fl;
    } alu_res_t;

    function automatic logic add_ovf(input logic a7, input logic b7, input logic r7);
        return (a7 == b7) && (r7 != a7);
    endfunction

    function automatic logic sub_ovf(input logic a7, input logic b7, input logic r7);
        return (a7 != b7) && (r7 != a7);
    endfunction

    function automatic logic [DW-1:0] pack_status(input flags_t f);
        logic [DW-1:0] s;
        s       = '0;
        s[ST_N] = f.n;
        s[ST_V] = f.v;
        s[ST_Z] = f.z;
        s[ST_C] = f.c;
        return s;
    endfunction

endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
    import bcd_alu_pkg::*;
#(
    parameter bit SUB = 1'b0
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output alu_res_t      res
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;

    generate
        if (SUB) begin : g_sub
            assign b_eff = ~b;
        end else begin : g_add
            assign b_eff = b;
        end
    endgenerate

    assign sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};

    always_comb begin
        res.value = sum[DW-1:0];
        res.fl.c  = sum[DW];
        res.fl.n  = sum[DW-1];
        res.fl.z  = (sum[DW-1:0] == '0);
        res.fl.v  = SUB ? sub_ovf(a[DW-1], b[DW-1], sum[DW-1])
                        : add_ovf(a[DW-1], b[DW-1], sum[DW-1]);
    end
endmodule

// File: rtl/bcd_alu_dadd.sv
module bcd_alu_dadd
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          late,
    input  logic          bin_zero,
    output alu_res_t      res
);
    logic [NW:0]   lo_raw;
    logic          lo_carry;
    logic [NW-1:0] lo_fix;
    logic [DW:0]   mid;
    logic          hi_carry;
    logic [DW-1:0] fin;

    assign lo_raw   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    assign lo_carry = (lo_raw >= LO_LIMIT);
    assign lo_fix   = lo_carry ? (lo_raw[NW-1:0] + ADJ_NIB) : lo_raw[NW-1:0];

    assign mid = {1'b0, a[DW-1:NW], {NW{1'b0}}}
               + {1'b0, b[DW-1:NW], {NW{1'b0}}}
               + {{(DW-NW+1){1'b0}}, lo_fix}
               + (lo_carry ? DIGIT_CARRY : '0);

    assign hi_carry = mid[DW] | (mid[DW-1:0] >= HI_LIMIT);
    assign fin      = mid[DW-1:0] + (hi_carry ? ADJ_HI : '0);

    always_comb begin
        res.value = fin;
        res.fl.c  = hi_carry;
        res.fl.v  = add_ovf(a[DW-1], b[DW-1], mid[DW-1]);
        if (late) begin
            res.fl.n = fin[DW-1];
            res.fl.z = (fin == '0);
        end else begin
            res.fl.n = mid[DW-1];
            res.fl.z = bin_zero;
        end
    end
endmodule

// File: rtl/bcd_alu_dsub.sv
module bcd_alu_dsub
    import bcd_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          late,
    input  flags_t        bin_fl,
    output alu_res_t      res
);
    logic [NW:0]   lo_raw;
    logic          lo_borrow;
    logic [NW-1:0] lo_fix;
    logic [DW:0]   mid;
    logic          hi_borrow;
    logic [DW-1:0] adj;
    logic [DW-1:0] fin;

    assign lo_raw    = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, ~cin};
    assign lo_borrow = lo_raw[NW];
    assign lo_fix    = (lo_borrow && !late) ? (lo_raw[NW-1:0] - ADJ_NIB) : lo_raw[NW-1:0];

    assign mid = {1'b0, a[DW-1:NW], lo_fix}
               - {1'b0, b[DW-1:NW], {NW{1'b0}}}
               - (lo_borrow ? DIGIT_CARRY : '0);

    assign hi_borrow = mid[DW];
    assign adj       = mid[DW-1:0] - (hi_borrow ? ADJ_HI : '0);
    assign fin       = (late && lo_borrow) ? (adj - {{(DW-NW){1'b0}}, ADJ_NIB}) : adj;

    always_comb begin
        res.value = fin;
        res.fl.v  = bin_fl.v;
        res.fl.c  = bin_fl.c;
        if (late) begin
            res.fl.n = fin[DW-1];
            res.fl.z = (fin == '0);
        end else begin
            res.fl.n = bin_fl.n;
            res.fl.z = bin_fl.z;
        end
    end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    input  logic          op_sub,
    input  logic          dec_en,
    input  logic          cmos_mode,
    output logic [DW-1:0] result_o,
    output logic [DW-1:0] status_o
);
    localparam int NUM_BIN = 2;

    alu_res_t  bin_res [NUM_BIN];
    alu_res_t  dadd_res;
    alu_res_t  dsub_res;
    alu_res_t  sel_res;
    alu_res_t  out_q;
    path_sel_e path;
    variant_e  variant;

    for (genvar g = 0; g < NUM_BIN; g++) begin : g_bin
        bcd_alu_bin #(.SUB(g[0])) u_bin (
            .a   (opnd_a),
            .b   (opnd_b),
            .cin (carry_in),
            .res (bin_res[g])
        );
    end

    assign variant = variant_e'(cmos_mode);

    bcd_alu_dadd u_dadd (
        .a        (opnd_a),
        .b        (opnd_b),
        .cin      (carry_in),
        .late     (variant == VAR_LATE),
        .bin_zero (bin_res[0].fl.z),
        .res      (dadd_res)
    );

    bcd_alu_dsub u_dsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .cin    (carry_in),
        .late   (variant == VAR_LATE),
        .bin_fl (bin_res[1].fl),
        .res    (dsub_res)
    );

    assign path = path_sel_e'({dec_en, op_sub});

    always_comb begin
        unique case (path)
            SEL_BADD: sel_res = bin_res[0];
            SEL_BSUB: sel_res = bin_res[1];
            SEL_DADD: sel_res = dadd_res;
            SEL_DSUB: sel_res = dsub_res;
            default:  sel_res = bin_res[0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= sel_res;
        end
    end

    assign result_o = out_q.value;
    assign status_o = pack_status(out_q.fl);
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] opnd_a,
    input logic [7:0] opnd_b,
    input logic       carry_in,
    input logic       op_sub,
    input logic       dec_en,
    input logic       cmos_mode,
    input logic [7:0] result_o,
    input logic [7:0] status_o
);
    // R1
    bin_add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!dec_en && !op_sub)) |->
        ({status_o[0], result_o} ==
         ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)} + {8'b0, $past(carry_in)})));

    // R7
    early_sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dec_en && op_sub && !cmos_mode)) |->
        (status_o[0] == ({1'b0, $past(opnd_a)} >=
                         ({1'b0, $past(opnd_b)} + {8'b0, !$past(carry_in)}))));

    // R9
    late_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dec_en && cmos_mode)) |->
        (status_o[7] == result_o[7] && status_o[1] == (result_o == 8'h00)));

    // R11
    status_gap_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[5:2] == 4'b0000);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result_o == 8'h00 && status_o == 8'h00));

    // R12
    bcd_digits_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dec_en && !op_sub) &&
         $past(opnd_a[3:0] <= 4'd9 && opnd_a[7:4] <= 4'd9 &&
               opnd_b[3:0] <= 4'd9 && opnd_b[7:4] <= 4'd9)) |->
        (result_o[3:0] <= 4'd9 && result_o[7:4] <= 4'd9));
endmodule

bind bcd_alu bcd_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .op_sub    (op_sub),
    .dec_en    (dec_en),
    .cmos_mode (cmos_mode),
    .result_o  (result_o),
    .status_o  (status_o)
);

// File: tb/bcd_alu_bench.sv
`timescale 1ns/1ps
module bcd_alu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic       carry_in = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_en = 1'b0;
    logic       cmos_mode = 1'b0;
    logic [7:0] result_o;
    logic [7:0] status_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int    r;
        bit    n, v, z, c;
        string tr, tn, tv, tz, tc;
        bit    bcd_chk;
        int    bcd_r;
        bit    bcd_c;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    bcd_alu u_bcd_alu (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .op_sub(op_sub), .dec_en(dec_en),
        .cmos_mode(cmos_mode), .result_o(result_o), .status_o(status_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input int a, input int b, input int ci,
                                   input bit sub, input bit dec, input bit late);
        exp_t e;
        int t, r, lo, m, bz;
        bit lc, lb;
        bit bn, bv, bzf, bc;
        // binary reference for both operations
        if (!sub) t = a + b + ci; else t = a - b - (1 - ci);
        r   = t & 255;
        bn  = r[7];
        bzf = (r == 0);
        if (!sub) begin
            bc = (t > 255);
            bv = (((a ^ r) & (b ^ r) & 128) != 0);
        end else begin
            bc = (t >= 0);
            bv = (((a ^ b) & (a ^ r) & 128) != 0);
        end
        e.bcd_chk = 0; e.bcd_r = 0; e.bcd_c = 0;
        if (!dec) begin
            e.r = r; e.n = bn; e.v = bv; e.z = bzf; e.c = bc;
            e.tr = sub ? "R2" : "R1";
            e.tn = e.tr; e.tv = e.tr; e.tz = e.tr; e.tc = e.tr;
        end else if (!sub) begin
            bz = (((a + b + ci) & 255) == 0);
            lo = (a & 15) + (b & 15) + ci;
            lc = (lo >= 10);
            if (lc) lo = (lo + 6) & 15;
            m  = (a & 240) + (b & 240) + lo + (lc ? 16 : 0);
            e.c = (m > 255) || ((m & 255) >= 160);
            e.r = e.c ? ((m + 96) & 255) : (m & 255);
            e.v = (((a ^ m) & (b ^ m) & 128) != 0);
            e.tr = "R3"; e.tc = "R3"; e.tv = "R4";
            if (late) begin
                e.n = e.r[7]; e.z = (e.r == 0); e.tn = "R9"; e.tz = "R9";
            end else begin
                e.n = m[7]; e.z = bz; e.tn = "R4"; e.tz = "R5";
            end
            if ((a & 15) <= 9 && (a >> 4) <= 9 && (b & 15) <= 9 && (b >> 4) <= 9) begin
                t = (a >> 4) * 10 + (a & 15) + (b >> 4) * 10 + (b & 15) + ci;
                e.bcd_chk = 1;
                e.bcd_c   = (t >= 100);
                t         = t % 100;
                e.bcd_r   = ((t / 10) << 4) | (t % 10);
            end
        end else begin
            lo = (a & 15) - (b & 15) - (1 - ci);
            lb = (lo < 0);
            if (lb) lo = late ? (lo & 15) : ((lo - 6) & 15);
            m = ((a & 240) | lo) - (b & 240) - (lb ? 16 : 0);
            if (m < 0) m = m - 96;
            r = m & 255;
            if (late && lb) r = (r - 6) & 255;
            e.r = r; e.v = bv; e.c = bc;
            if (late) begin
                e.n = r[7]; e.z = (r == 0);
                e.tr = "R8"; e.tn = "R9"; e.tz = "R9"; e.tv = "R9"; e.tc = "R9";
            end else begin
                e.n = bn; e.z = bzf;
                e.tr = "R6"; e.tn = "R7"; e.tz = "R7"; e.tv = "R7"; e.tc = "R7";
            end
        end
        return e;
    endfunction

    task automatic drive(input int a, input int b, input int ci,
                         input bit sub, input bit dec, input bit late);
        @(negedge clk);
        opnd_a = a[7:0]; opnd_b = b[7:0]; carry_in = ci[0];
        op_sub = sub; dec_en = dec; cmos_mode = late;
        exp_q.push_back(model(a, b, ci, sub, dec, late));
    endtask

    // monitor: result registered at the edge after the inputs were driven
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                #1;
                check(result_o == e.r[7:0], e.tr, "result", result_o, e.r);
                // R11: N=bit7, V=bit6, Z=bit1, C=bit0, bits 5..2 zero
                check(status_o[7] == e.n, e.tn, "N(bit7)", status_o[7], e.n);
                check(status_o[6] == e.v, e.tv, "V(bit6)", status_o[6], e.v);
                check(status_o[1] == e.z, e.tz, "Z(bit1)", status_o[1], e.z);
                check(status_o[0] == e.c, e.tc, "C(bit0)", status_o[0], e.c);
                check(status_o[5:2] == 4'b0, "R11", "unused", status_o[5:2], 0);
                if (e.bcd_chk) begin
                    check(result_o == e.bcd_r[7:0], "R12", "decimal sum", result_o, e.bcd_r);
                    check(status_o[0] == e.bcd_c, "R12", "decimal carry", status_o[0], e.bcd_c);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset clears outputs even with nonzero inputs present
        opnd_a = 8'h99; opnd_b = 8'h99; carry_in = 1'b1; dec_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(result_o == 8'h00, "R10", "reset result", result_o, 0);
        check(status_o == 8'h00, "R10", "reset status", status_o, 0);
        rst = 1'b0;
        for (int mode = 0; mode < 6; mode++) begin
            bit dec, sub, late;
            dec  = (mode >= 2);
            sub  = dec ? mode[0] : mode[0];
            late = dec ? mode[2] ^ (mode == 4 || mode == 5 ? 1'b0 : 1'b0) : mode[0];
            if (mode == 2) begin sub = 0; late = 0; end
            if (mode == 3) begin sub = 1; late = 0; end
            if (mode == 4) begin sub = 0; late = 1; end
            if (mode == 5) begin sub = 1; late = 1; end
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 30; bi++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        drive(a, (bi == 29) ? 255 : bi * 9, ci, sub, dec, late);
                    end
                end
            end
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule